// File: doc/BRIEF.md
# Serial Transmitter with Port-Shared Pin and Break Control

This block is one transmit channel of a serial interface whose output pin is shared with a general-purpose port bit. A transmit-enable bit picks the pin's driver. When the bit is set, the serial shifter drives the pin. When the bit is clear, a port data bit and a port direction bit drive it. While the shifter is off, software uses the port pair to hold the line at the idle (mark) level, or to force a steady low break.

The host loads a byte into a transmit data register, and that write clears a data-empty flag. When the channel is enabled, the shifter takes the byte and sets the flag again. It then sends the byte in one of two modes. The asynchronous mode sends 8N1 frames paced by a one-cycle bit-tick input. The synchronous mode sends eight bits against a generated serial clock.

Three receive error flags (overrun, parity, framing) can be set and cleared by the host. In synchronous mode, any of them being set holds back the start of a new transmission. Clearing the transmit-enable bit resets the transmitter at once, even in the middle of a frame.

Top module: `sertx_brk`

## Requirements
- R1: After reset: pinOe=0, busy=0, tdrEmpty=1, txEnd=1, errFlags=0, sclkOut=1, rxEnOut=0, and the port data and direction bits are 0.
- R2: While transmit enable is 0, pinOe equals the port direction bit and pinOut equals the port data bit. While it is 1 and the shifter is idle, pinOe=1 and pinOut=1.
- R3: A control write with transmit enable 0 aborts any frame at the same clock edge. At that edge busy goes to 0 and the pin is handed to the port pair. After re-enabling, the line idles at 1 with no rest of the old frame.
- R4: With port data 0 and port direction 1, clearing transmit enable makes the pin drive a steady 0 (pinOe=1, pinOut=0) whatever bitTick does.
- R5: A data write clears tdrEmpty at its edge. If the channel is enabled and may start, the next edge loads the shifter: busy rises and tdrEmpty returns to 1 together.
- R6: An asynchronous frame is a start bit 0, then data bits 0..7 with LSB first, then a stop bit 1. The start bit appears at load, and each later bit appears on one bitTick. busy falls on the 10th tick with the pin at 1.
- R7: Synchronous mode has no start or stop bits. sclkOut idles at 1 and toggles on every bitTick. Data bit i (LSB first) appears on the pin at the i-th falling toggle. busy falls on the 16th tick with sclkOut=1.
- R8: In synchronous mode, a set error flag (errFlags bit0 overrun, bit1 parity, bit2 framing) keeps a written byte from starting, and tdrEmpty stays 0. The start follows one edge after the flags are cleared. Error flags do not block asynchronous mode.
- R9: errSet bits set the matching errFlags bits and errClr bits clear them; when both hit the same bit, set wins. Any control write, including one that clears receive enable, leaves errFlags unchanged.
- R10: txEnd is 1 exactly when the shifter is idle and tdrEmpty is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWr | input | 1 | Write strobe for the control bits |
| ctrlTxEn | input | 1 | Transmit enable value to write |
| ctrlRxEn | input | 1 | Receive enable value to write |
| ctrlSync | input | 1 | Mode to write: 1 synchronous, 0 asynchronous |
| tdrWr | input | 1 | Write strobe for the transmit data register |
| tdrData | input | 8 | Byte to transmit |
| portWr | input | 1 | Write strobe for the port pair |
| portDat | input | 1 | Port data bit value |
| portDir | input | 1 | Port direction value (1 = output) |
| errSet | input | 3 | Per-flag set strobes |
| errClr | input | 3 | Per-flag clear strobes |
| bitTick | input | 1 | One-cycle bit-rate tick |
| pinOut | output | 1 | Pin output level |
| pinOe | output | 1 | Pin output enable |
| sclkOut | output | 1 | Synchronous serial clock |
| busy | output | 1 | Shifter active |
| tdrEmpty | output | 1 | Data register empty flag |
| txEnd | output | 1 | Transmission ended flag |
| errFlags | output | 3 | Receive error flags |
| rxEnOut | output | 1 | Stored receive enable bit |

## Verification
If the frame counter or the shift register held a wrong value, the pin would show a wrong bit, or busy would end early or late. The pin is compared on every bitTick, so such a fault shows up within one bit time. If the abort path kept stale state, busy or a low level would stay on the pin in the first cycle after the disabling write. A broken error interlock would show as busy rising, or tdrEmpty returning to 1, one edge after a byte written in synchronous mode with a flag pending.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef struct packed {
    logic load;
    logic shiftOut;
    logic clkFall;
    logic clkRise;
    logic finish;
    logic abort;
    logic syncMode;
  } txStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ASYNC = 2'd1,
    ST_SYNC  = 2'd2
  } txState_e;
endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWr,
  input  logic       ctrlTxEn,
  input  logic       ctrlRxEn,
  input  logic       ctrlSync,
  input  logic       bitTick,
  input  logic       tdrEmpty,
  input  logic       errAny,
  output logic       txEn,
  output logic       rxEn,
  output logic       syncMode,
  output logic       busy,
  output txStrobes_t stb
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] ASYNC_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] SYNC_LAST  = CNT_W'(DATA_W - 1);

  txState_e         state;
  logic [CNT_W-1:0] bitCnt;
  logic             phase;
  logic             txEnNxt;
  logic             startOk;

  assign txEnNxt = ctrlWr ? ctrlTxEn : txEn;
  assign busy    = (state != ST_IDLE);
  assign startOk = (state == ST_IDLE) && txEn && txEnNxt && !tdrEmpty
                   && !(syncMode && errAny);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEn     <= 1'b0;
      rxEn     <= 1'b0;
      syncMode <= 1'b0;
    end else if (ctrlWr) begin
      txEn     <= ctrlTxEn;
      rxEn     <= ctrlRxEn;
      syncMode <= ctrlSync;
    end
  end

  always_comb begin
    stb          = '0;
    stb.syncMode = syncMode;
    if (!txEnNxt) begin
      stb.abort = 1'b1;
    end else begin
      case (state)
        ST_IDLE:  stb.load = startOk;
        ST_ASYNC: if (bitTick) begin
          if (bitCnt == ASYNC_LAST) stb.finish = 1'b1;
          else                      stb.shiftOut = 1'b1;
        end
        ST_SYNC: if (bitTick) begin
          if (!phase) begin
            stb.clkFall  = 1'b1;
            stb.shiftOut = 1'b1;
          end else begin
            stb.clkRise = 1'b1;
            if (bitCnt == SYNC_LAST) stb.finish = 1'b1;
          end
        end
        default: stb.abort = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      phase  <= 1'b0;
    end else if (stb.abort || stb.finish) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      phase  <= 1'b0;
    end else if (stb.load) begin
      state  <= syncMode ? ST_SYNC : ST_ASYNC;
      bitCnt <= '0;
      phase  <= 1'b0;
    end else if (state == ST_ASYNC && stb.shiftOut) begin
      bitCnt <= bitCnt + 1'b1;
    end else if (state == ST_SYNC) begin
      if (stb.clkFall) phase <= 1'b1;
      if (stb.clkRise) begin
        phase  <= 1'b0;
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // R3
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !txEnNxt) |=> !busy);

  // R8
  err_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && syncMode && errAny) |=> (state == ST_IDLE));

  // R5
  start_needs_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && tdrEmpty) |=> (state == ST_IDLE));
endmodule

// File: rtl/sertx_dpath.sv
module sertx_dpath
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        stb,
  input  logic              txEn,
  input  logic              tdrWr,
  input  logic [DATA_W-1:0] tdrData,
  input  logic              portWr,
  input  logic              portDat,
  input  logic              portDir,
  input  logic [ERR_W-1:0]  errSet,
  input  logic [ERR_W-1:0]  errClr,
  output logic              tdrEmpty,
  output logic [ERR_W-1:0]  errFlags,
  output logic              pinOut,
  output logic              pinOe,
  output logic              sclkOut
);
  logic [DATA_W-1:0] tdrReg;
  logic [DATA_W:0]   shReg;
  logic              lineReg;
  logic              portDatReg;
  logic              portDirReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portDatReg <= 1'b0;
      portDirReg <= 1'b0;
    end else if (portWr) begin
      portDatReg <= portDat;
      portDirReg <= portDir;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tdrReg   <= '0;
      tdrEmpty <= 1'b1;
    end else if (tdrWr) begin
      tdrReg   <= tdrData;
      tdrEmpty <= 1'b0;
    end else if (stb.load) begin
      tdrEmpty <= 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < ERR_W; i++) begin : g_err
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          errFlags[i] <= 1'b0;
        else if (errSet[i]) errFlags[i] <= 1'b1;
        else if (errClr[i]) errFlags[i] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '1;
      lineReg <= 1'b1;
      sclkOut <= 1'b1;
    end else if (stb.abort || stb.finish) begin
      shReg   <= '1;
      lineReg <= 1'b1;
      sclkOut <= 1'b1;
    end else if (stb.load) begin
      shReg   <= {1'b1, tdrReg};
      lineReg <= stb.syncMode;
      sclkOut <= 1'b1;
    end else begin
      if (stb.shiftOut) begin
        lineReg <= shReg[0];
        shReg   <= {1'b1, shReg[DATA_W:1]};
      end
      if (stb.clkFall) sclkOut <= 1'b0;
      if (stb.clkRise) sclkOut <= 1'b1;
    end
  end

  assign pinOut = txEn ? lineReg : portDatReg;
  assign pinOe  = txEn ? 1'b1    : portDirReg;

  // R6
  start_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && !stb.syncMode && !stb.abort) |=> !lineReg);

  // R5
  load_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && !tdrWr) |=> tdrEmpty);

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errSet == '0 && errClr == '0) |=> $stable(errFlags));
endmodule

// File: rtl/sertx_brk.sv
module sertx_brk
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic              ctrlTxEn,
  input  logic              ctrlRxEn,
  input  logic              ctrlSync,
  input  logic              tdrWr,
  input  logic [DATA_W-1:0] tdrData,
  input  logic              portWr,
  input  logic              portDat,
  input  logic              portDir,
  input  logic [ERR_W-1:0]  errSet,
  input  logic [ERR_W-1:0]  errClr,
  input  logic              bitTick,
  output logic              pinOut,
  output logic              pinOe,
  output logic              sclkOut,
  output logic              busy,
  output logic              tdrEmpty,
  output logic              txEnd,
  output logic [ERR_W-1:0]  errFlags,
  output logic              rxEnOut
);
  txStrobes_t stb;
  logic       txEn;
  logic       syncMode;

  sertx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWr   (ctrlWr),
    .ctrlTxEn (ctrlTxEn),
    .ctrlRxEn (ctrlRxEn),
    .ctrlSync (ctrlSync),
    .bitTick  (bitTick),
    .tdrEmpty (tdrEmpty),
    .errAny   (|errFlags),
    .txEn     (txEn),
    .rxEn     (rxEnOut),
    .syncMode (syncMode),
    .busy     (busy),
    .stb      (stb)
  );

  sertx_dpath #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .txEn     (txEn),
    .tdrWr    (tdrWr),
    .tdrData  (tdrData),
    .portWr   (portWr),
    .portDat  (portDat),
    .portDir  (portDir),
    .errSet   (errSet),
    .errClr   (errClr),
    .tdrEmpty (tdrEmpty),
    .errFlags (errFlags),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .sclkOut  (sclkOut)
  );

  assign txEnd = !busy && tdrEmpty;

  // R2
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && !busy) |-> (pinOe && pinOut));

  // R7
  async_sclk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!syncMode) |-> sclkOut);
endmodule

// File: tb/sim_sertx_brk.sv
`timescale 1ns/1ps
module sim_sertx_brk;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWr = 0, ctrlTxEn = 0, ctrlRxEn = 0, ctrlSync = 0;
  logic       tdrWr = 0;
  logic [7:0] tdrData = '0;
  logic       portWr = 0, portDat = 0, portDir = 0;
  logic [2:0] errSet = '0, errClr = '0;
  logic       bitTick = 0;
  logic       pinOut, pinOe, sclkOut, busy, tdrEmpty, txEnd, rxEnOut;
  logic [2:0] errFlags;

  int nChk = 0;
  int nBad = 0;

  always #4 clk = ~clk;

  sertx_brk u0 (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlTxEn(ctrlTxEn),
    .ctrlRxEn(ctrlRxEn), .ctrlSync(ctrlSync), .tdrWr(tdrWr), .tdrData(tdrData),
    .portWr(portWr), .portDat(portDat), .portDir(portDir), .errSet(errSet),
    .errClr(errClr), .bitTick(bitTick), .pinOut(pinOut), .pinOe(pinOe),
    .sclkOut(sclkOut), .busy(busy), .tdrEmpty(tdrEmpty), .txEnd(txEnd),
    .errFlags(errFlags), .rxEnOut(rxEnOut)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wrCtrl(input logic te, input logic re, input logic sy);
    ctrlWr = 1; ctrlTxEn = te; ctrlRxEn = re; ctrlSync = sy;
    cyc();
    ctrlWr = 0;
  endtask

  task automatic wrPort(input logic d, input logic dir);
    portWr = 1; portDat = d; portDir = dir;
    cyc();
    portWr = 0;
  endtask

  task automatic wrTdr(input logic [7:0] d);
    tdrWr = 1; tdrData = d;
    cyc();
    tdrWr = 0;
  endtask

  task automatic tick();
    bitTick = 1;
    cyc();
    bitTick = 0;
  endtask

  task automatic errOp(input logic [2:0] s, input logic [2:0] c);
    errSet = s; errClr = c;
    cyc();
    errSet = '0; errClr = '0;
  endtask

  task automatic testReset();
    chk("R1", "pinOe", pinOe, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "tdrEmpty", tdrEmpty, 1);
    chk("R1", "txEnd", txEnd, 1);
    chk("R1", "errFlags", errFlags, 0);
    chk("R1", "sclkOut", sclkOut, 1);
    chk("R1", "rxEnOut", rxEnOut, 0);
    chk("R1", "pinOut", pinOut, 0);
  endtask

  task automatic testPortMux();
    wrPort(1, 0);
    chk("R2", "oe dir0", pinOe, 0);
    wrPort(1, 1);
    chk("R2", "oe dir1", pinOe, 1);
    chk("R2", "out dat1", pinOut, 1);
    wrPort(0, 1);
    chk("R2", "out dat0", pinOut, 0);
    wrPort(1, 1);
    wrCtrl(1, 0, 0);
    chk("R2", "enabled oe", pinOe, 1);
    chk("R2", "enabled idle", pinOut, 1);
    chk("R10", "txEnd idle", txEnd, 1);
  endtask

  task automatic testAsync(input logic [7:0] d);
    wrTdr(d);
    chk("R5", "empty after write", tdrEmpty, 0);
    chk("R5", "not yet busy", busy, 0);
    chk("R10", "txEnd data waiting", txEnd, 0);
    cyc();
    chk("R5", "busy after load", busy, 1);
    chk("R5", "empty after load", tdrEmpty, 1);
    chk("R10", "txEnd while busy", txEnd, 0);
    chk("R6", "start bit", pinOut, 0);
    cyc();
    chk("R6", "start held", pinOut, 0);
    for (int i = 0; i < 8; i++) begin
      tick();
      chk("R6", "data bit", pinOut, d[i]);
    end
    tick();
    chk("R6", "stop bit", pinOut, 1);
    chk("R6", "busy in stop", busy, 1);
    tick();
    chk("R6", "busy end", busy, 0);
    chk("R6", "line idle", pinOut, 1);
    chk("R10", "txEnd done", txEnd, 1);
  endtask

  task automatic testSync(input logic [7:0] d);
    wrCtrl(1, 0, 1);
    wrTdr(d);
    cyc();
    chk("R7", "busy", busy, 1);
    chk("R7", "sclk idle", sclkOut, 1);
    chk("R7", "no start bit", pinOut, 1);
    for (int i = 0; i < 8; i++) begin
      tick();
      chk("R7", "sclk low", sclkOut, 0);
      chk("R7", "bit at fall", pinOut, d[i]);
      tick();
      chk("R7", "sclk high", sclkOut, 1);
      chk("R7", "bit held", pinOut, d[i]);
      if (i < 7) chk("R7", "busy mid", busy, 1);
    end
    chk("R7", "busy end", busy, 0);
    chk("R7", "line idle", pinOut, 1);
  endtask

  task automatic testBreak();
    wrCtrl(1, 0, 0);
    wrTdr(8'hFF);
    cyc();
    tick(); tick();
    chk("R3", "busy mid frame", busy, 1);
    wrPort(0, 1);
    chk("R3", "still serial", pinOut, 1);
    wrCtrl(0, 0, 0);
    chk("R3", "abort busy", busy, 0);
    chk("R4", "break oe", pinOe, 1);
    chk("R4", "break level", pinOut, 0);
    for (int i = 0; i < 12; i++) tick();
    chk("R4", "break held", pinOut, 0);
    chk("R4", "break oe held", pinOe, 1);
    wrPort(1, 1);
    chk("R2", "mark via port", pinOut, 1);
    wrCtrl(1, 0, 0);
    chk("R3", "reenable idle", pinOut, 1);
    chk("R3", "reenable busy", busy, 0);
    tick();
    chk("R3", "no stale frame", pinOut, 1);
  endtask

  task automatic testErrBlock();
    wrCtrl(1, 1, 1);
    errOp(3'b010, 3'b000);
    wrTdr(8'h5A);
    for (int i = 0; i < 4; i++) cyc();
    chk("R8", "blocked busy", busy, 0);
    chk("R8", "blocked empty", tdrEmpty, 0);
    errOp(3'b000, 3'b111);
    chk("R8", "flags cleared", errFlags, 0);
    chk("R8", "start pending", busy, 0);
    cyc();
    chk("R8", "starts after clear", busy, 1);
    for (int i = 0; i < 16; i++) tick();
    chk("R8", "frame done", busy, 0);
    wrCtrl(1, 0, 0);
    errOp(3'b100, 3'b000);
    wrTdr(8'h3C);
    cyc();
    chk("R8", "async not blocked", busy, 1);
    for (int i = 0; i < 10; i++) tick();
    errOp(3'b000, 3'b111);
  endtask

  task automatic testErrFlags();
    errOp(3'b110, 3'b000);
    chk("R9", "set", errFlags, 3'b110);
    wrCtrl(1, 1, 0);
    chk("R9", "rxEn set", rxEnOut, 1);
    wrCtrl(1, 0, 0);
    chk("R9", "rxEn cleared", rxEnOut, 0);
    chk("R9", "flags kept", errFlags, 3'b110);
    errOp(3'b001, 3'b011);
    chk("R9", "set wins / clear", errFlags, 3'b101);
    errOp(3'b000, 3'b111);
    chk("R9", "all clear", errFlags, 3'b000);
  endtask

  initial begin
    #(8 * 200000);
    nChk++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    cyc();
    testReset();
    rstN = 1;
    cyc();
    testReset();
    testPortMux();
    testAsync(8'hA5);
    testAsync(8'h0F);
    testSync(8'hC3);
    testBreak();
    testErrBlock();
    testErrFlags();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule